// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that shuttles data between system memory and a peripheral's data stream. Software places a chain of descriptors in memory, loads the address of the first one into the channel, picks a direction and sets the run bit. The engine then walks the chain without further help. For each descriptor it reads a control word, a buffer address and a link address. It moves the requested number of bytes one 32-bit word at a time. It then either follows the link to the next descriptor or, if the descriptor is flagged as the last one, stops.

Each stop, whether successful or not, leaves a 4-bit event code in the channel control register, clears the run bit and sets a sticky interrupt flag. The interrupt output is that flag gated by an enable bit. Memory is reached through a single-word request/acknowledge master port. Toward the peripheral there is a one-word holding buffer. In the outbound direction the peripheral takes a word with a strobe, and taking while nothing is held is an underrun. In the inbound direction the peripheral pushes words in, and pushing into a full buffer is an overrun. The peripheral can also signal that it has finished early.

Top module: `chain_dma`

## Requirements
- R1: After reset, every register (global 0x00, irq enable 0x04, irq status 0x08, descriptor pointer 0x0C, channel control 0x10) reads 0, and irq, mem_req, tx_valid and rx_ready are low.
- R2: Global register bit 0 is the engine enable and reads back as written. A channel-control write with bit 7 (run) set while the enable is 0 is ignored: run stays 0 and no memory request is issued.
- R3: A descriptor at address P is read as three words: flags at P, buffer address at P+4 and link address at P+8. In the flags word, bits [15:0] are a byte count moved as ceil(count/4) words, where a count of 0 moves nothing. Bit 30 must be 1, or the channel stops with event 3.
- R4: When flags bit 31 is clear, the next descriptor is fetched from the link address. When it is set, the channel stops with event 15 after the descriptor's data has been moved.
- R5: With channel-control bit 22 = 0 (memory to peripheral), the words are presented on tx_data with tx_valid in ascending address order, descriptor after descriptor. A held word stays stable until tx_take.
- R6: With bit 22 = 1 (peripheral to memory), words pushed on rx_data while rx_ready is high are written to ascending addresses starting at the buffer address.
- R7: In the outbound direction, tx_take while no word is held stops the channel with event 1 (underrun).
- R8: In the inbound direction, rx_push while a word is already held stops the channel with event 2 (overrun).
- R9: mem_err on a descriptor read stops the channel with event 3. mem_err on a data read or write stops it with event 4.
- R10: periph_done while the byte counts of the chain are not yet exhausted stops the channel with event 5 (early end).
- R11: Run (bit 7) reads 1 from the start until the channel stops, and then clears by itself. The event code (bits [3:0]) reads 0 from a start until the stop, then holds the stop's code until the next start or soft reset.
- R12: Every stop sets irq status bit 0. irq equals irq-enable bit 0 AND status bit 0. Writing 1 to status bit 0 clears it.
- R13: Writing global bit 8 (soft reset) aborts any transfer and returns all registers to their reset values, including the enable. Bit 8 always reads 0.
- R14: While run is 1, writes to the descriptor pointer and to channel control are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until mem_ack or mem_err |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory transfer completes this cycle |
| mem_err | input | 1 | Memory transfer fails this cycle |
| tx_valid | output | 1 | Outbound word held |
| tx_data | output | 32 | Outbound word |
| tx_take | input | 1 | Peripheral consumes the outbound word |
| rx_ready | output | 1 | Inbound buffer empty and channel receiving |
| rx_push | input | 1 | Peripheral delivers an inbound word |
| rx_data | input | 32 | Inbound word |
| periph_done | input | 1 | Peripheral signals the end of its transfer |

## Verification
The hardest situations to reach are the two stream faults and the early end, because each needs the peripheral to misbehave at a moment set by the engine's internal progress. The bench models the peripheral with selectable behaviours. One mode takes or pushes on every cycle regardless of the handshake, which forces an underrun or an overrun during the first descriptor fetch. A timed periph_done pulse lands while a long chain is still transferring. A stalled consumer holds the channel mid-transfer, so that the soft reset and the writes that must be ignored while running can be applied to a channel that is known to be busy.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

    localparam int WORD_W     = 32;
    localparam int REG_AW     = 5;
    localparam int CNT_W      = 16;

    localparam int GBL_EN_BIT   = 0;
    localparam int GBL_SRST_BIT = 8;
    localparam int CH_RUN_BIT   = 7;
    localparam int CH_DIR_BIT   = 22;
    localparam int FL_FMT_BIT   = 30;
    localparam int FL_END_BIT   = 31;

    typedef enum logic [3:0] {
        EV_NONE  = 4'd0,
        EV_UNDER = 4'd1,
        EV_OVER  = 4'd2,
        EV_DESC  = 4'd3,
        EV_DATA  = 4'd4,
        EV_EARLY = 4'd5,
        EV_OK    = 4'd15
    } dma_event_e;

    typedef enum logic [2:0] {
        SEL_GLOBAL = 3'd0,
        SEL_IRQ_EN = 3'd1,
        SEL_IRQ_ST = 3'd2,
        SEL_DPTR   = 3'd3,
        SEL_CHAN   = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLAGS,
        ST_BUF,
        ST_LINK,
        ST_XFER,
        ST_DRAIN
    } eng_state_e;

    typedef struct packed {
        logic             last;
        logic             fmt_ok;
        logic [CNT_W-1:0] bytes;
    } desc_flags_t;

    function automatic desc_flags_t decode_flags(input logic [WORD_W-1:0] w);
        desc_flags_t f;
        f.last   = w[FL_END_BIT];
        f.fmt_ok = w[FL_FMT_BIT];
        f.bytes  = w[CNT_W-1:0];
        return f;
    endfunction

    function automatic logic [CNT_W-1:0] word_bytes(input logic [CNT_W-1:0] rem);
        return (rem >= CNT_W'(4)) ? CNT_W'(4) : rem;
    endfunction

endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
    import chain_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic                 stop_i,
    input  dma_event_e           stop_evt_i,
    output logic                 start_o,
    output logic                 soft_rst_o,
    output logic                 en_o,
    output logic                 dir_o,
    output logic [AW-1:0]        dptr_o,
    output logic                 irq_o
);
    reg_sel_e   sel;
    logic       en_q, ie_q, ist_q, run_q, dir_q;
    logic [AW-1:0] dptr_q;
    dma_event_e evt_q;

    assign sel        = reg_sel_e'(reg_addr[REG_AW-1:2]);
    assign soft_rst_o = reg_we && (sel == SEL_GLOBAL) && reg_wdata[GBL_SRST_BIT];
    assign start_o    = reg_we && (sel == SEL_CHAN) && reg_wdata[CH_RUN_BIT]
                        && !run_q && en_q && !soft_rst_o;
    assign en_o   = en_q;
    assign dir_o  = dir_q;
    assign dptr_o = dptr_q;
    assign irq_o  = ie_q && ist_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst_o) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            ist_q  <= 1'b0;
            run_q  <= 1'b0;
            dir_q  <= 1'b0;
            dptr_q <= '0;
            evt_q  <= EV_NONE;
        end else begin
            if (reg_we) begin
                case (sel)
                    SEL_GLOBAL: en_q <= reg_wdata[GBL_EN_BIT];
                    SEL_IRQ_EN: ie_q <= reg_wdata[0];
                    SEL_IRQ_ST: if (reg_wdata[0]) ist_q <= 1'b0;
                    SEL_DPTR:   if (!run_q) dptr_q <= reg_wdata[AW-1:0];
                    SEL_CHAN:   if (!run_q) dir_q <= reg_wdata[CH_DIR_BIT];
                    default: ;
                endcase
            end
            if (start_o) begin
                run_q <= 1'b1;
                evt_q <= EV_NONE;
            end
            if (stop_i) begin
                run_q <= 1'b0;
                evt_q <= stop_evt_i;
                ist_q <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_GLOBAL: reg_rdata[GBL_EN_BIT] = en_q;
            SEL_IRQ_EN: reg_rdata[0] = ie_q;
            SEL_IRQ_ST: reg_rdata[0] = ist_q;
            SEL_DPTR:   reg_rdata = WORD_W'(dptr_q);
            SEL_CHAN: begin
                reg_rdata[3:0]        = evt_q;
                reg_rdata[CH_RUN_BIT] = run_q;
                reg_rdata[CH_DIR_BIT] = dir_q;
            end
            default: ;
        endcase
    end

    p_run_drop_r11: assert property (@(posedge clk) disable iff (rst || soft_rst_o)
        stop_i |=> !run_q);
    p_irq_on_stop_r12: assert property (@(posedge clk) disable iff (rst || soft_rst_o)
        (stop_i && ie_q) |=> irq_o);
    p_evt_legal_r11: assert property (@(posedge clk) disable iff (rst)
        evt_q inside {EV_NONE, EV_UNDER, EV_OVER, EV_DESC, EV_DATA, EV_EARLY, EV_OK});

endmodule

// File: rtl/chain_dma_stream.sv
module chain_dma_stream
    import chain_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              dir_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_data_i,
    input  logic              take_i,
    input  logic              tx_take,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_data,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              rx_ready,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o,
    output logic              underrun_o,
    output logic              overrun_o
);
    logic              full_q;
    logic [WORD_W-1:0] word_q;

    assign full_o     = full_q;
    assign word_o     = word_q;
    assign tx_valid   = full_q && !dir_i;
    assign tx_data    = word_q;
    assign rx_ready   = active_i && dir_i && !full_q;
    assign underrun_o = active_i && !dir_i && tx_take && !full_q;
    assign overrun_o  = active_i && dir_i && rx_push && full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            word_q <= '0;
        end else if (!active_i) begin
            full_q <= 1'b0;
        end else if (!dir_i) begin
            if (load_i) begin
                full_q <= 1'b1;
                word_q <= load_data_i;
            end else if (tx_take && full_q) begin
                full_q <= 1'b0;
            end
        end else begin
            if (rx_push && !full_q) begin
                full_q <= 1'b1;
                word_q <= rx_data;
            end else if (take_i) begin
                full_q <= 1'b0;
            end
        end
    end

    p_tx_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (active_i && tx_valid && !tx_take) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
    import chain_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              en_i,
    input  logic              dir_i,
    input  logic [AW-1:0]     dptr_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              buf_full_i,
    input  logic [WORD_W-1:0] buf_word_i,
    input  logic              underrun_i,
    input  logic              overrun_i,
    input  logic              periph_done,
    output logic              buf_load_o,
    output logic              buf_take_o,
    output logic              busy_o,
    output logic              stop_o,
    output dma_event_e        stop_evt_o
);
    localparam logic [AW-1:0] OFS_BUF  = AW'(4);
    localparam logic [AW-1:0] OFS_LINK = AW'(8);

    eng_state_e       state;
    logic [AW-1:0]    dptr_q, base_q, link_q;
    logic [CNT_W-1:0] rem_q;
    logic             last_q;
    desc_flags_t      fl;
    logic             xfer_empty, exhausted, finished;

    assign fl         = decode_flags(mem_rdata);
    assign busy_o     = (state != ST_IDLE);
    assign xfer_empty = (state == ST_XFER) && (rem_q == '0);
    assign exhausted  = (state == ST_DRAIN) || (xfer_empty && last_q);
    assign finished   = (xfer_empty && last_q && dir_i) || ((state == ST_DRAIN) && !buf_full_i);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dptr_q;
        mem_wdata = buf_word_i;
        case (state)
            ST_FLAGS: mem_req = 1'b1;
            ST_BUF: begin
                mem_req  = 1'b1;
                mem_addr = dptr_q + OFS_BUF;
            end
            ST_LINK: begin
                mem_req  = 1'b1;
                mem_addr = dptr_q + OFS_LINK;
            end
            ST_XFER: begin
                mem_addr = base_q;
                if (rem_q != '0) begin
                    mem_req = dir_i ? buf_full_i : !buf_full_i;
                    mem_we  = dir_i;
                end
            end
            default: ;
        endcase
    end

    assign buf_load_o = (state == ST_XFER) && mem_req && !dir_i && mem_ack;
    assign buf_take_o = (state == ST_XFER) && mem_req &&  dir_i && mem_ack;

    always_comb begin
        stop_o     = 1'b0;
        stop_evt_o = EV_NONE;
        if (busy_o) begin
            if (mem_req && mem_err) begin
                stop_o     = 1'b1;
                stop_evt_o = (state == ST_XFER) ? EV_DATA : EV_DESC;
            end else if (underrun_i) begin
                stop_o     = 1'b1;
                stop_evt_o = EV_UNDER;
            end else if (overrun_i) begin
                stop_o     = 1'b1;
                stop_evt_o = EV_OVER;
            end else if (periph_done && !exhausted) begin
                stop_o     = 1'b1;
                stop_evt_o = EV_EARLY;
            end else if ((state == ST_FLAGS) && mem_ack && !fl.fmt_ok) begin
                stop_o     = 1'b1;
                stop_evt_o = EV_DESC;
            end else if (finished) begin
                stop_o     = 1'b1;
                stop_evt_o = EV_OK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            dptr_q <= '0;
            base_q <= '0;
            link_q <= '0;
            rem_q  <= '0;
            last_q <= 1'b0;
        end else if (stop_o) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start_i) begin
                    dptr_q <= dptr_i;
                    state  <= ST_FLAGS;
                end
                ST_FLAGS: if (mem_ack) begin
                    last_q <= fl.last;
                    rem_q  <= fl.bytes;
                    state  <= ST_BUF;
                end
                ST_BUF: if (mem_ack) begin
                    base_q <= mem_rdata[AW-1:0];
                    state  <= ST_LINK;
                end
                ST_LINK: if (mem_ack) begin
                    link_q <= mem_rdata[AW-1:0];
                    state  <= ST_XFER;
                end
                ST_XFER: begin
                    if (rem_q == '0) begin
                        if (last_q) begin
                            state <= ST_DRAIN;
                        end else begin
                            dptr_q <= link_q;
                            state  <= ST_FLAGS;
                        end
                    end else if (mem_req && mem_ack) begin
                        base_q <= base_q + OFS_BUF;
                        rem_q  <= rem_q - word_bytes(rem_q);
                    end
                end
                default: ;
            endcase
        end
    end

    p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err && !underrun_i && !overrun_i && !periph_done)
        |=> (mem_req && $stable(mem_addr)));
    p_start_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |-> en_i);
    p_overrun_stops_r8: assert property (@(posedge clk) disable iff (rst)
        (overrun_i && busy_o) |=> !busy_o);

endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_take,
    output logic              rx_ready,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              periph_done
);
    logic              start, soft_rst, en, dir, stop, busy;
    logic              core_rst;
    logic [AW-1:0]     dptr;
    dma_event_e        stop_evt;
    logic              buf_load, buf_take, buf_full, underrun, overrun;
    logic [WORD_W-1:0] buf_word;

    assign core_rst = rst || soft_rst;

    chain_dma_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .stop_i     (stop),
        .stop_evt_i (stop_evt),
        .start_o    (start),
        .soft_rst_o (soft_rst),
        .en_o       (en),
        .dir_o      (dir),
        .dptr_o     (dptr),
        .irq_o      (irq)
    );

    chain_dma_engine #(.AW(AW)) u_engine (
        .clk         (clk),
        .rst         (core_rst),
        .start_i     (start),
        .en_i        (en),
        .dir_i       (dir),
        .dptr_i      (dptr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .buf_full_i  (buf_full),
        .buf_word_i  (buf_word),
        .underrun_i  (underrun),
        .overrun_i   (overrun),
        .periph_done (periph_done),
        .buf_load_o  (buf_load),
        .buf_take_o  (buf_take),
        .busy_o      (busy),
        .stop_o      (stop),
        .stop_evt_o  (stop_evt)
    );

    chain_dma_stream u_stream (
        .clk         (clk),
        .rst         (core_rst),
        .active_i    (busy),
        .dir_i       (dir),
        .load_i      (buf_load),
        .load_data_i (mem_rdata),
        .take_i      (buf_take),
        .tx_take     (tx_take),
        .rx_push     (rx_push),
        .rx_data     (rx_data),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .rx_ready    (rx_ready),
        .full_o      (buf_full),
        .word_o      (buf_word),
        .underrun_o  (underrun),
        .overrun_o   (overrun)
    );

endmodule

// File: tb/chain_dma_tb.sv
module chain_dma_tb;
    localparam logic [4:0] A_GBL = 5'h00, A_IE = 5'h04, A_IS = 5'h08, A_DP = 5'h0C, A_CC = 5'h10;
    localparam logic [31:0] F_FMT = 32'h4000_0000, F_END = 32'h8000_0000;
    localparam logic [31:0] RUN = 32'h0000_0080, DIR_IN = 32'h0040_0000;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq, mem_req, mem_we, tx_valid, rx_ready;
    logic [31:0] mem_addr, mem_wdata, tx_data;
    logic [31:0] mem_rdata = '0, rx_data = '0;
    logic mem_ack = 1'b0, mem_err = 1'b0, tx_take = 1'b0, rx_push = 1'b0, periph_done = 1'b0;

    logic [31:0] mem  [0:255];
    logic [31:0] wmem [0:255];
    logic [31:0] txlog [0:1023];
    int tx_n = 0, rx_cnt = 0;
    int tx_mode = 0, rx_mode = 0;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    chain_dma u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_take(tx_take), .rx_ready(rx_ready), .rx_push(rx_push), .rx_data(rx_data),
        .periph_done(periph_done)
    );

    // memory model: addresses at or above 0x400 fail
    initial forever begin
        @(negedge clk);
        if (mem_req && !mem_ack && !mem_err) begin
            if (mem_addr >= 32'h400) mem_err = 1'b1;
            else begin
                mem_ack = 1'b1;
                if (mem_we) wmem[mem_addr[9:2]] = mem_wdata;
                else mem_rdata = mem[mem_addr[9:2]];
            end
        end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
    end

    // outbound consumer: 0 idle, 1 takes when valid, 2 takes every cycle
    initial forever begin
        @(negedge clk);
        if (tx_mode == 1 && tx_valid) begin
            tx_take = 1'b1;
            txlog[tx_n] = tx_data;
            tx_n++;
        end else tx_take = (tx_mode == 2);
    end

    // inbound producer: 0 idle, 1 pushes when ready, 2 pushes every cycle
    initial forever begin
        @(negedge clk);
        if ((rx_mode == 1 && rx_ready) || rx_mode == 2) begin
            rx_push = 1'b1;
            rx_data = 32'h5A00_0000 + 32'(rx_cnt);
            rx_cnt++;
        end else rx_push = 1'b0;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end act=running exp=finished");
        summary();
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic put_desc(input int a, input logic [31:0] f, input logic [31:0] b, input logic [31:0] l);
        mem[a/4] = f; mem[a/4+1] = b; mem[a/4+2] = l; mem[a/4+3] = 32'h0;
    endtask

    task automatic wait_stop(output logic [31:0] cc);
        cc = 32'h0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(A_CC, cc);
            if (!cc[7]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_GBL, v); check("R1 global", v, 0);
        rd(A_IE, v);  check("R1 irq enable", v, 0);
        rd(A_IS, v);  check("R1 irq status", v, 0);
        rd(A_DP, v);  check("R1 desc ptr", v, 0);
        rd(A_CC, v);  check("R1 channel", v, 0);
        check("R1 pins", {irq, mem_req, tx_valid, rx_ready}, 0);
    endtask

    task automatic t_enable_gate();
        logic [31:0] v;
        logic seen = 1'b0;
        put_desc(32'h100, F_FMT | F_END | 8, 32'h200, 0);
        wr(A_DP, 32'h100);
        wr(A_CC, RUN);
        for (int i = 0; i < 6; i++) begin @(negedge clk); seen |= mem_req; end
        rd(A_CC, v); check("R2 run ignored while disabled", v[7], 0);
        check("R2 no memory request", seen, 0);
        wr(A_GBL, 32'h1);
        rd(A_GBL, v); check("R2 enable readback", v, 1);
    endtask

    task automatic t_tx_chain();
        logic [31:0] v;
        int base;
        for (int k = 0; k < 4; k++) begin
            mem[(32'h200 >> 2) + k] = 32'hA000_0000 + 32'(k);
            mem[(32'h280 >> 2) + k] = 32'hB000_0000 + 32'(k);
        end
        put_desc(32'h100, F_FMT | 8, 32'h200, 32'h140);
        put_desc(32'h140, F_FMT | F_END | 6, 32'h280, 0);
        wr(A_IE, 1);
        wr(A_DP, 32'h100);
        base = tx_n;
        tx_mode = 1;
        wr(A_CC, RUN);
        rd(A_CC, v); check("R11 run set after start", v[7], 1);
        wait_stop(v);
        repeat (4) @(negedge clk);
        tx_mode = 0;
        check("R11 run self-clears", v[7], 0);
        check("R4 success event", v[3:0], 15);
        check("R3 word count", 32'(tx_n - base), 4);
        check("R5 word0", txlog[base],   32'hA000_0000);
        check("R5 word1", txlog[base+1], 32'hA000_0001);
        check("R4 word2 from linked desc", txlog[base+2], 32'hB000_0000);
        check("R4 word3 from linked desc", txlog[base+3], 32'hB000_0001);
        rd(A_IS, v); check("R12 status set", v, 1);
        check("R12 irq high", irq, 1);
        wr(A_IS, 1);
        rd(A_IS, v); check("R12 status cleared", v, 0);
        check("R12 irq low", irq, 0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        int base;
        put_desc(32'h100, F_FMT | 0, 32'h3C0, 32'h140);
        put_desc(32'h140, F_FMT | F_END | 12, 32'h300, 0);
        for (int k = 0; k < 8; k++) wmem[(32'h300 >> 2) + k] = 32'hDEAD_0000;
        wmem[32'h3C0 >> 2] = 32'hDEAD_0000;
        wr(A_DP, 32'h100);
        base = rx_cnt;
        rx_mode = 1;
        wr(A_CC, RUN | DIR_IN);
        rd(A_CC, v); check("R11 event zero while running", v[3:0], 0);
        wr(A_DP, 32'h1C0);
        rd(A_DP, v); check("R14 pointer write ignored", v, 32'h100);
        wait_stop(v);
        rx_mode = 0;
        check("R6 success event", v[3:0], 15);
        for (int k = 0; k < 3; k++)
            check("R6 inbound word", wmem[(32'h300 >> 2) + k], 32'h5A00_0000 + 32'(base + k));
        check("R6 no word past count", wmem[(32'h300 >> 2) + 3], 32'hDEAD_0000);
        check("R3 zero-count desc untouched", wmem[32'h3C0 >> 2], 32'hDEAD_0000);
        wr(A_IS, 1);
    endtask

    task automatic t_underrun();
        logic [31:0] v;
        put_desc(32'h100, F_FMT | F_END | 16, 32'h200, 0);
        wr(A_DP, 32'h100);
        tx_mode = 2;
        wr(A_CC, RUN);
        wait_stop(v);
        tx_mode = 0;
        check("R7 underrun event", v[3:0], 1);
        check("R7 run clear", v[7], 0);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        put_desc(32'h100, F_FMT | F_END | 16, 32'h300, 0);
        wr(A_DP, 32'h100);
        rx_mode = 2;
        wr(A_CC, RUN | DIR_IN);
        wait_stop(v);
        rx_mode = 0;
        check("R8 overrun event", v[3:0], 2);
        check("R8 rx_ready low after stop", rx_ready, 0);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        tx_mode = 1;
        put_desc(32'h100, F_END | 8, 32'h200, 0);
        wr(A_DP, 32'h100);
        wr(A_CC, RUN);
        wait_stop(v);
        check("R3 format bit clear", v[3:0], 3);
        wr(A_DP, 32'h400);
        wr(A_CC, RUN);
        wait_stop(v);
        check("R9 descriptor fetch error", v[3:0], 3);
        put_desc(32'h100, F_FMT | F_END | 8, 32'h400, 0);
        wr(A_DP, 32'h100);
        wr(A_CC, RUN);
        wait_stop(v);
        check("R9 data access error", v[3:0], 4);
        tx_mode = 0;
    endtask

    task automatic t_early();
        logic [31:0] v;
        for (int k = 0; k < 16; k++) mem[(32'h200 >> 2) + k] = 32'(k);
        put_desc(32'h100, F_FMT | F_END | 64, 32'h200, 0);
        wr(A_DP, 32'h100);
        tx_mode = 1;
        wr(A_CC, RUN);
        repeat (12) @(negedge clk);
        periph_done = 1'b1;
        @(negedge clk);
        periph_done = 1'b0;
        wait_stop(v);
        tx_mode = 0;
        check("R10 early end event", v[3:0], 5);
        rd(A_CC, v); check("R11 event holds", v[3:0], 5);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        put_desc(32'h100, F_FMT | F_END | 16, 32'h200, 0);
        wr(A_DP, 32'h100);
        wr(A_CC, RUN);
        repeat (20) @(negedge clk);
        rd(A_CC, v); check("R13 channel stalled busy", v[7], 1);
        wr(A_CC, DIR_IN);
        rd(A_CC, v); check("R14 channel write ignored", v[22], 0);
        wr(A_GBL, 32'h101);
        rd(A_GBL, v); check("R13 global cleared", v, 0);
        rd(A_CC, v);  check("R13 channel cleared", v, 0);
        rd(A_DP, v);  check("R13 pointer cleared", v, 0);
        rd(A_IE, v);  check("R13 irq enable cleared", v, 0);
        rd(A_IS, v);  check("R13 irq status cleared", v, 0);
        check("R13 bus idle", {mem_req, tx_valid, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_enable_gate();
        t_tx_chain();
        t_rx();
        t_underrun();
        t_overrun();
        t_errors();
        t_early();
        t_soft_reset();
        summary();
        $finish;
    end
endmodule